// File: doc/BRIEF.md
# Indexed Address Translation Window Bank

This block holds two banks of address translation windows, one for traffic leaving the host (outbound) and one for traffic arriving from the link (inbound). Each bank has a parameterised number of windows. Software never sees all windows at once. It first writes a selector register that picks a direction and a window number. It then reads and writes the lower bound, the 32-bit upper bound, the 64-bit destination and two control words of that one window through a fixed group of offsets.

Register writes only stage a window's new settings. The geometry used for translation (bounds, destination, type and enable) is copied into the live copy of the window when control word 2 is written.

For each lookup, the block compares the address against the live, enabled windows of the requested direction and picks the lowest-numbered window that matches. One cycle later it returns the translated address. When the winning window is an outbound configuration window, the result also carries the bus number, the device/function number and the offset inside a configuration space. When no window matches, the address passes through unchanged and the hit flag stays low.

Top module: `xlat_window_bank`

## Requirements
- R1: The selector register (offset 0x900) keeps bit 31 as the direction (1 = inbound, 0 = outbound) and the low log2(NUM_WIN) bits as the window number. Reading it back shows every other bit as zero.
- R2: The per-window registers of the selected window are: control 1 at 0x904, control 2 at 0x908, lower bound low half at 0x90C, lower bound high half at 0x910, 32-bit upper bound at 0x914, destination low half at 0x918 and destination high half at 0x91C. A read returns the staged value. The two halves of a 64-bit field are written and read independently. Any other offset reads as zero.
- R3: Writes to the bounds, the destination or control 1 leave translation unchanged until control 2 of that window is written.
- R4: A live window of memory type (control 1 equal to 0) with enable set (control 2 bit 31) matches address A when base <= A <= {32'b0, limit}. It returns destination + (A - base).
- R5: An outbound window whose control 1 is nonzero is a configuration window. On a match it returns the address as in R4 and raises res_cfg. It returns bus = destination[31:24], devfn = destination[23:16], and offset = (A - base) masked to CFG_OFF_W bits (0xFFF by default).
- R6: An inbound window whose control 1 is nonzero never matches.
- R7: When several live windows of the requested direction match, the one with the lowest window number decides the result.
- R8: When no window matches, res_hit and res_cfg are 0 and res_addr equals the looked-up address.
- R9: After reset, every window has base 0, destination 0, limit 0xFFFFFFFF, control 1 = 0 and enable clear. The one exception is inbound window 0, whose control 2 reads 0x80000000 and which matches every inbound address below 2^32.
- R10: res_valid and the result fields appear on the clock edge that follows the edge that samples in_valid.
- R11: A lookup only considers windows of the direction given by in_dir.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| in_valid | input | 1 | Lookup request |
| in_dir | input | 1 | Lookup direction, 1 = inbound |
| in_addr | input | 64 | Address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_addr | output | 64 | Translated or passed-through address |
| res_cfg | output | 1 | Match was an outbound configuration window |
| res_bus | output | 8 | Bus number for a configuration match |
| res_devfn | output | 8 | Device/function number for a configuration match |
| res_cfg_off | output | CFG_OFF_W | Offset inside configuration space |

## Verification
A register read is combinational, so reg_rdata is due in the same cycle that reg_addr changes. The bench samples it a short delay after driving the offset at the falling edge. A register write lands on the next rising edge, and a control 2 write makes the new geometry live at that same edge. A lookup driven at a falling edge is captured at the next rising edge and its result is registered there. The bench therefore samples every result field at the following falling edge, exactly one edge after the request, and never before the staging write that R3 depends on has been committed.

// File: rtl/atw_pkg.sv
package atw_pkg;
  localparam int ADDR_W = 64;

  localparam logic [11:0] OFF_VIEW    = 12'h900;
  localparam logic [11:0] OFF_CTL1    = 12'h904;
  localparam logic [11:0] OFF_CTL2    = 12'h908;
  localparam logic [11:0] OFF_BASE_LO = 12'h90C;
  localparam logic [11:0] OFF_BASE_HI = 12'h910;
  localparam logic [11:0] OFF_LIMIT   = 12'h914;
  localparam logic [11:0] OFF_TGT_LO  = 12'h918;
  localparam logic [11:0] OFF_TGT_HI  = 12'h91C;

  localparam int EN_BIT  = 31;
  localparam int DIR_BIT = 31;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [31:0]       limit;
    logic [ADDR_W-1:0] target;
    logic [31:0]       ctl1;
    logic [31:0]       ctl2;
  } win_stage_t;

  typedef struct packed {
    logic              en;
    logic              is_cfg;
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
    logic [ADDR_W-1:0] target;
  } win_live_t;

  function automatic logic win_covers(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] lo,
                                      input logic [ADDR_W-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  function automatic logic [ADDR_W-1:0] win_xlat(input logic [ADDR_W-1:0] a,
                                                 input logic [ADDR_W-1:0] lo,
                                                 input logic [ADDR_W-1:0] tgt);
    return tgt + (a - lo);
  endfunction
endpackage

// File: rtl/atw_slot.sv
module atw_slot
  import atw_pkg::*;
#(
  parameter bit START_ON = 1'b0,
  parameter bit INBOUND  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [11:0]       wr_off,
  input  logic [31:0]       wdata,
  input  logic [ADDR_W-1:0] look_addr,
  output win_stage_t        stage,
  output win_live_t         live,
  output logic              hit,
  output logic              commit
);
  assign commit = wr_en && (wr_off == OFF_CTL2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage.base   <= '0;
      stage.limit  <= 32'hFFFF_FFFF;
      stage.target <= '0;
      stage.ctl1   <= '0;
      stage.ctl2   <= START_ON ? 32'h8000_0000 : 32'h0;
      live.en      <= START_ON;
      live.is_cfg  <= 1'b0;
      live.lo      <= '0;
      live.hi      <= {32'h0, 32'hFFFF_FFFF};
      live.target  <= '0;
    end else if (wr_en) begin
      case (wr_off)
        OFF_CTL1:    stage.ctl1 <= wdata;
        OFF_CTL2: begin
          stage.ctl2  <= wdata;
          live.en     <= wdata[EN_BIT];
          live.is_cfg <= (stage.ctl1 != 32'h0);
          live.lo     <= stage.base;
          live.hi     <= {32'h0, stage.limit};
          live.target <= stage.target;
        end
        OFF_BASE_LO: stage.base[31:0]    <= wdata;
        OFF_BASE_HI: stage.base[63:32]   <= wdata;
        OFF_LIMIT:   stage.limit         <= wdata;
        OFF_TGT_LO:  stage.target[31:0]  <= wdata;
        OFF_TGT_HI:  stage.target[63:32] <= wdata;
        default: ;
      endcase
    end
  end

  assign hit = live.en && !(INBOUND && live.is_cfg) &&
               win_covers(look_addr, live.lo, live.hi);
endmodule

// File: rtl/atw_pick.sv
module atw_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = i[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/xlat_window_bank.sv
module xlat_window_bank
  import atw_pkg::*;
#(
  parameter int NUM_WIN   = 16,
  parameter int CFG_OFF_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [11:0]          reg_addr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  input  logic                 in_valid,
  input  logic                 in_dir,
  input  logic [63:0]          in_addr,
  output logic                 res_valid,
  output logic                 res_hit,
  output logic [63:0]          res_addr,
  output logic                 res_cfg,
  output logic [7:0]           res_bus,
  output logic [7:0]           res_devfn,
  output logic [CFG_OFF_W-1:0] res_cfg_off
);
  localparam int IDXW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam logic [31:0] VIEW_KEEP = (32'h1 << DIR_BIT) | 32'(NUM_WIN - 1);

  logic            vp_dir;
  logic [IDXW-1:0] vp_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vp_dir <= 1'b0;
      vp_idx <= '0;
    end else if (reg_we && reg_addr == OFF_VIEW) begin
      vp_dir <= reg_wdata[DIR_BIT];
      vp_idx <= reg_wdata[IDXW-1:0];
    end
  end

  win_stage_t      stage [2][NUM_WIN];
  win_live_t       live  [2][NUM_WIN];
  logic [NUM_WIN-1:0] hit_vec [2];
  logic [NUM_WIN-1:0] commit_vec [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
      logic sel_wr;
      assign sel_wr = reg_we && (reg_addr != OFF_VIEW) &&
                      (vp_dir == d[0]) && (vp_idx == i[IDXW-1:0]);
      atw_slot #(
        .START_ON (d == 1 && i == 0),
        .INBOUND  (d == 1)
      ) u_slot (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (sel_wr),
        .wr_off    (reg_addr),
        .wdata     (reg_wdata),
        .look_addr (in_addr),
        .stage     (stage[d][i]),
        .live      (live[d][i]),
        .hit       (hit_vec[d][i]),
        .commit    (commit_vec[d][i])
      );
    end
  end

  // Register readback of the selected window's staged values
  win_stage_t cur;
  assign cur = stage[vp_dir][vp_idx];

  always_comb begin
    case (reg_addr)
      OFF_VIEW:    reg_rdata = {vp_dir, 31'h0} | 32'(vp_idx);
      OFF_CTL1:    reg_rdata = cur.ctl1;
      OFF_CTL2:    reg_rdata = cur.ctl2;
      OFF_BASE_LO: reg_rdata = cur.base[31:0];
      OFF_BASE_HI: reg_rdata = cur.base[63:32];
      OFF_LIMIT:   reg_rdata = cur.limit;
      OFF_TGT_LO:  reg_rdata = cur.target[31:0];
      OFF_TGT_HI:  reg_rdata = cur.target[63:32];
      default:     reg_rdata = 32'h0;
    endcase
  end

  // Lookup: priority pick among the requested direction
  logic            pick_found;
  logic [IDXW-1:0] pick_idx;

  atw_pick #(.N(NUM_WIN)) u_pick (
    .req   (hit_vec[in_dir]),
    .found (pick_found),
    .idx   (pick_idx)
  );

  win_live_t   win;
  logic [63:0] win_off;
  logic        nxt_cfg;
  assign win     = live[in_dir][pick_idx];
  assign win_off = in_addr - win.lo;
  assign nxt_cfg = pick_found && !in_dir && win.is_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_addr    <= '0;
      res_cfg     <= 1'b0;
      res_bus     <= '0;
      res_devfn   <= '0;
      res_cfg_off <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_hit     <= pick_found;
        res_addr    <= pick_found ? win_xlat(in_addr, win.lo, win.target) : in_addr;
        res_cfg     <= nxt_cfg;
        res_bus     <= nxt_cfg ? win.target[31:24] : 8'h0;
        res_devfn   <= nxt_cfg ? win.target[23:16] : 8'h0;
        res_cfg_off <= nxt_cfg ? win_off[CFG_OFF_W-1:0] : '0;
      end
    end
  end

  logic unused_view_keep;
  assign unused_view_keep = ^VIEW_KEEP;
endmodule

// File: rtl/xlat_window_bank_chk.sv
module xlat_window_bank_chk
  import atw_pkg::*;
#(
  parameter int NUM_WIN = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] reg_addr,
  input logic [31:0] reg_rdata,
  input logic        in_valid,
  input logic        in_dir,
  input logic [63:0] in_addr,
  input logic        res_valid,
  input logic        res_hit,
  input logic [63:0] res_addr,
  input logic        res_cfg
);
  localparam logic [31:0] KEEP = 32'h8000_0000 | 32'(NUM_WIN - 1);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);

  a_r8_miss_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (res_hit || (res_addr == $past(in_addr) && !res_cfg)));

  a_r5_cfg_outbound_hit: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (!res_cfg || (res_hit && !$past(in_dir))));

  a_r6_inbound_never_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_dir) |=> !res_cfg);

  a_r1_view_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == OFF_VIEW) |-> ((reg_rdata & ~KEEP) == 32'h0));
endmodule

bind xlat_window_bank xlat_window_bank_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .in_valid  (in_valid),
  .in_dir    (in_dir),
  .in_addr   (in_addr),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_addr  (res_addr),
  .res_cfg   (res_cfg)
);

// File: tb/test_xlat_window_bank.sv
module test_xlat_window_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = 12'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0;
  logic        in_dir = 1'b0;
  logic [63:0] in_addr = 64'h0;
  logic        res_valid, res_hit, res_cfg;
  logic [63:0] res_addr;
  logic [7:0]  res_bus, res_devfn;
  logic [11:0] res_cfg_off;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  xlat_window_bank i_xlat_window_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
    .in_dir(in_dir), .in_addr(in_addr), .res_valid(res_valid),
    .res_hit(res_hit), .res_addr(res_addr), .res_cfg(res_cfg),
    .res_bus(res_bus), .res_devfn(res_devfn), .res_cfg_off(res_cfg_off)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pick(input logic dir, input int idx);
    wr(12'h900, {dir, 31'h0} | 32'(idx));
  endtask

  // Expected: hit flag and address, one edge after the request
  task automatic look(input string req, input logic dir, input logic [63:0] a,
                      input logic exp_hit, input logic [63:0] exp_addr);
    @(negedge clk);
    in_valid = 1'b1; in_dir = dir; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(res_valid), 64'd1);
    check({req, " hit"}, 64'(res_hit), 64'(exp_hit));
    check({req, " addr"}, res_addr, exp_addr);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(12'h900, d); check("R9 view reset", 64'(d), 64'h0);
    rd(12'h914, d); check("R9 limit reset", 64'(d), 64'hFFFF_FFFF);
    rd(12'h908, d); check("R9 outbound ctl2 reset", 64'(d), 64'h0);
    pick(1'b1, 0);
    rd(12'h908, d); check("R9 inbound0 ctl2 reset", 64'(d), 64'h8000_0000);
    look("R9 inbound default pass", 1'b1, 64'h1234, 1'b1, 64'h1234);
    look("R9 inbound above 4G miss", 1'b1, 64'h1_0000_0000, 1'b0, 64'h1_0000_0000);
    look("R11 outbound all off", 1'b0, 64'h1234, 1'b0, 64'h1234);
    check("R8 miss cfg low", 64'(res_cfg), 64'd0);
  endtask

  task automatic t_view();
    logic [31:0] d;
    wr(12'h900, 32'hFFFF_FFFF);
    rd(12'h900, d); check("R1 view mask inbound", 64'(d), 64'h8000_000F);
    wr(12'h900, 32'h7FFF_FFF5);
    rd(12'h900, d); check("R1 view mask outbound", 64'(d), 64'h5);
    rd(12'h920, d); check("R2 unknown offset zero", 64'(d), 64'h0);
  endtask

  task automatic t_stage_mem();
    logic [31:0] d;
    pick(1'b0, 3);
    wr(12'h90C, 32'h1000);
    wr(12'h914, 32'h1FFF);
    wr(12'h918, 32'h8000_0000);
    wr(12'h91C, 32'h1);
    look("R3 staged not live", 1'b0, 64'h1800, 1'b0, 64'h1800);
    rd(12'h90C, d); check("R2 base lo readback", 64'(d), 64'h1000);
    rd(12'h91C, d); check("R2 target hi readback", 64'(d), 64'h1);
    wr(12'h908, 32'h8000_0000);
    look("R4 mid window", 1'b0, 64'h1800, 1'b1, 64'h1_8000_0800);
    look("R4 top edge", 1'b0, 64'h1FFF, 1'b1, 64'h1_8000_0FFF);
    look("R4 bottom edge", 1'b0, 64'h1000, 1'b1, 64'h1_8000_0000);
    look("R4 above limit", 1'b0, 64'h2000, 1'b0, 64'h2000);
    look("R4 below base", 1'b0, 64'h0FFF, 1'b0, 64'h0FFF);
    look("R11 inbound ignores outbound", 1'b1, 64'h1_0000_1800, 1'b0, 64'h1_0000_1800);
    wr(12'h918, 32'h0);
    look("R3 target change staged", 1'b0, 64'h1800, 1'b1, 64'h1_8000_0800);
    wr(12'h918, 32'h8000_0000);
  endtask

  task automatic t_priority();
    pick(1'b0, 1);
    wr(12'h90C, 32'h1800);
    wr(12'h914, 32'h27FF);
    wr(12'h918, 32'h4000_0000);
    wr(12'h908, 32'h8000_0000);
    look("R7 lower index wins", 1'b0, 64'h1900, 1'b1, 64'h4000_0100);
    look("R7 only high index", 1'b0, 64'h1100, 1'b1, 64'h1_8000_0100);
    look("R7 only low index", 1'b0, 64'h2500, 1'b1, 64'h4000_0D00);
    wr(12'h908, 32'h0);
    look("R4 disable falls to next", 1'b0, 64'h1900, 1'b1, 64'h1_8000_0900);
  endtask

  task automatic t_halves();
    logic [31:0] d;
    pick(1'b0, 5);
    wr(12'h910, 32'h2);
    wr(12'h90C, 32'h10);
    rd(12'h910, d); check("R2 base hi kept", 64'(d), 64'h2);
    rd(12'h90C, d); check("R2 base lo kept", 64'(d), 64'h10);
  endtask

  task automatic t_cfg();
    pick(1'b0, 7);
    wr(12'h904, 32'h4);
    wr(12'h90C, 32'h9000_0000);
    wr(12'h914, 32'h9000_FFFF);
    wr(12'h918, 32'h0312_0000);
    wr(12'h908, 32'h8000_0000);
    look("R5 cfg hit", 1'b0, 64'h9000_2345, 1'b1, 64'h0312_2345);
    check("R5 cfg flag", 64'(res_cfg), 64'd1);
    check("R5 bus", 64'(res_bus), 64'h03);
    check("R5 devfn", 64'(res_devfn), 64'h12);
    check("R5 offset", 64'(res_cfg_off), 64'h345);
  endtask

  task automatic t_inbound_cfg();
    pick(1'b1, 0);
    wr(12'h908, 32'h0);
    look("R9 inbound0 disabled", 1'b1, 64'h150, 1'b0, 64'h150);
    pick(1'b1, 2);
    wr(12'h904, 32'h4);
    wr(12'h90C, 32'h100);
    wr(12'h914, 32'h1FF);
    wr(12'h918, 32'h7000);
    wr(12'h908, 32'h8000_0000);
    look("R6 inbound cfg no hit", 1'b1, 64'h150, 1'b0, 64'h150);
    wr(12'h904, 32'h0);
    look("R3 ctl1 staged", 1'b1, 64'h150, 1'b0, 64'h150);
    wr(12'h908, 32'h8000_0000);
    look("R6 inbound mem hit", 1'b1, 64'h150, 1'b1, 64'h7050);
    check("R6 no cfg flag", 64'(res_cfg), 64'd0);
  endtask

  initial begin
    #1;
    check("R10 reset valid", 64'(res_valid), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_view();
    t_stage_mem();
    t_priority();
    t_halves();
    t_cfg();
    t_inbound_cfg();
    @(negedge clk);
    check("R10 idle after request", 64'(res_valid), 64'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule